// File: doc/BRIEF.md
# Online Softmax Row Accumulator

This block computes the normalized attention output for one query row without ever holding the row's full set of scores. Scores arrive one tile at a time. Each tile carries `KEYS` scores and one value vector of `LANES` lanes per score. The block keeps three pieces of running state: the largest score seen so far, a running sum of exponential weights, and a weighted sum of value vectors.

When a tile brings a larger score, the block first rescales the old sum and the old vector to the new maximum. Only after that does it add the tile's own contributions. Every exponential-then-multiply step goes through one fused primitive. This primitive turns the score difference into an arithmetic right shift of the operand, so there is no separate exponential unit and no multiplier.

When the tile flagged as last has been folded in, a bit-serial divider divides every lane by the running sum. The block then presents the result and pulses a done flag. After that it clears its state for the next row.

Top module: `online_softmax_row`

## Requirements
- R1: While reset is asserted and right after it, `doneOut` is 0, `inReady` is 1 and `outVector` is all zeros.
- R2: A tile is taken only on a clock edge where `inValid` and `inReady` are both 1. `inReady` goes low on the next cycle and stays low until that tile has been folded into the state. After a tile taken with `inLast`=1, `inReady` stays low until the cycle in which `doneOut` is high.
- R3: The fused weight for a non-negative score difference d is fixed. Scores are signed 12-bit values with 4 fraction bits. The operand is arithmetically shifted right by min(floor(d/16), 8). Differences beyond 8 integer steps are clipped to a shift of 8.
- R4: For each tile, the new maximum is the larger of the running maximum and the tile's largest score. The running sum and every lane of the running vector are first replaced by the fused weight of (new maximum − old maximum) applied to them. Only then is the tile added.
- R5: Each score s of a tile adds the fused weight of (maximum − s) applied to 256 to the sum. It also adds the same weight applied to value×256 to each lane. Value lane l of key k sits at `inValues[(k*LANES+l)*8 +: 8]` as a signed 8-bit number. Score k sits at `inScores[k*12 +: 12]`.
- R6: After the last tile, lane l of the result is trunc_toward_zero(16·acc_l / sum). It is written as 14-bit two's complement at `outVector[l*14 +: 14]`.
- R7: `doneOut` is high for exactly one cycle per row. `outVector` changes only on the edge that raises `doneOut`, and it holds its value until the next row's done.
- R8: At the end of a row, the running maximum returns to −2048 (the most negative score) and the sum and vector return to zero. The next row's result therefore depends only on its own tiles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A tile is offered |
| inReady | output | 1 | Block can take a tile this cycle |
| inLast | input | 1 | Offered tile ends the row |
| inScores | input | KEYS*SW | Signed fixed-point scores, key k at k*SW |
| inValues | input | KEYS*LANES*VW | Signed value lanes, key k lane l at (k*LANES+l)*VW |
| doneOut | output | 1 | One-cycle pulse when the row result is valid |
| outVector | output | LANES*OW | Normalized result lanes, lane l at l*OW |

## Verification
Rows with identical scores reduce to a plain mean of the values, which isolates the sum and division path from any rescaling. Rows whose maximum climbs tile after tile exercise the rescale path on every tile. Rows whose maximum falls after the first tile keep the maximum fixed and test only the weighting of lower scores. A row that jumps from −2000 to 1500 drives the shift into its clip. Full-scale negative values check the sign handling in the divider. Random rows of one to six tiles, each checked against a bench model, catch state left over between rows and errors in the ordering of rescale and accumulate.

// File: rtl/osr_pkg.sv
package osr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCALE,
    ST_ACCUM,
    ST_DLOAD,
    ST_DIVIDE,
    ST_FINISH
  } osr_state_t;

  typedef struct packed {
    logic capture;
    logic rescale;
    logic accumulate;
    logic divLoad;
    logic divStep;
    logic finish;
  } osr_strobe_t;

endpackage

// File: rtl/osr_expmul.sv
// Fused exponential-times-operand: weight 2^-k realized as an arithmetic shift.
module osr_expmul #(
  parameter int DW   = 12,
  parameter int FRAC = 4,
  parameter int CAP  = 8,
  parameter int VALW = 32
) (
  input  logic [DW-1:0]          delta,
  input  logic signed [VALW-1:0] value,
  output logic signed [VALW-1:0] product
);
  localparam int IW = DW - FRAC;
  localparam logic [IW-1:0] CAPV = IW'(CAP);

  logic [IW-1:0] intPart;
  logic [IW-1:0] shiftAmt;

  always_comb begin
    intPart  = delta[DW-1:FRAC];
    shiftAmt = (intPart > CAPV) ? CAPV : intPart;
    product  = value >>> shiftAmt;
  end
endmodule

// File: rtl/osr_ctrl.sv
module osr_ctrl
  import osr_pkg::*;
#(
  parameter int QW = 13,
  localparam int IDXW = $clog2(QW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inValid,
  input  logic            inLast,
  output logic            inReady,
  output osr_strobe_t     ctl,
  output logic [IDXW-1:0] bitIdx
);
  osr_state_t state, nextState;
  logic lastReg;

  always_comb begin
    inReady        = (state == ST_IDLE);
    ctl            = '0;
    ctl.capture    = inReady && inValid;
    ctl.rescale    = (state == ST_SCALE);
    ctl.accumulate = (state == ST_ACCUM);
    ctl.divLoad    = (state == ST_DLOAD);
    ctl.divStep    = (state == ST_DIVIDE);
    ctl.finish     = (state == ST_FINISH);
    nextState      = state;
    unique case (state)
      ST_IDLE:   if (inValid) nextState = ST_SCALE;
      ST_SCALE:  nextState = ST_ACCUM;
      ST_ACCUM:  nextState = lastReg ? ST_DLOAD : ST_IDLE;
      ST_DLOAD:  nextState = ST_DIVIDE;
      ST_DIVIDE: if (bitIdx == '0) nextState = ST_FINISH;
      ST_FINISH: nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      lastReg <= 1'b0;
      bitIdx  <= '0;
    end else begin
      state <= nextState;
      if (ctl.capture) lastReg <= inLast;
      if (ctl.divLoad) bitIdx <= IDXW'(QW - 1);
      else if (ctl.divStep && bitIdx != '0) bitIdx <= bitIdx - 1'b1;
    end
  end
endmodule

// File: rtl/osr_datapath.sv
module osr_datapath
  import osr_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int KEYS    = 2,
  parameter int VW      = 8,
  parameter int SW      = 12,
  parameter int SFRAC   = 4,
  parameter int SUMFRAC = 8,
  parameter int OFRAC   = 4,
  parameter int AW      = 32,
  localparam int OW     = VW + OFRAC + 2,
  localparam int QW     = OW - 1,
  localparam int IDXW   = $clog2(QW)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  osr_strobe_t              ctl,
  input  logic [IDXW-1:0]          bitIdx,
  input  logic [KEYS*SW-1:0]       inScores,
  input  logic [KEYS*LANES*VW-1:0] inValues,
  output logic                     doneOut,
  output logic [LANES*OW-1:0]      outVector
);
  localparam int DIVW = AW + QW + OFRAC;
  localparam logic signed [SW-1:0] SCORE_MIN = {1'b1, {(SW-1){1'b0}}};
  localparam logic signed [AW-1:0] ONE = AW'(1) <<< SUMFRAC;

  logic signed [SW-1:0] tileScore [KEYS];
  logic signed [VW-1:0] tileVal   [KEYS][LANES];
  logic signed [SW-1:0] runMax, pendMax;
  logic signed [AW-1:0] runSum;
  logic signed [AW-1:0] runAcc [LANES];

  logic signed [SW-1:0] tileMax, candMax;
  logic signed [SW:0]   scaleDiffWide;
  logic [SW-1:0]        scaleDelta;
  logic signed [AW-1:0] scaledSum;
  logic signed [AW-1:0] scaledAcc [LANES];

  logic [SW-1:0]        keyDelta   [KEYS];
  logic signed [AW-1:0] keySumTerm [KEYS];
  logic signed [AW-1:0] keyAccTerm [KEYS][LANES];
  logic signed [AW-1:0] keyValExt  [KEYS][LANES];
  logic signed [AW-1:0] sumAdd;
  logic signed [AW-1:0] accAdd [LANES];

  logic [DIVW-1:0] rem [LANES];
  logic [QW-1:0]   quo [LANES];
  logic            negRes [LANES];
  logic [AW-1:0]   magAcc [LANES];
  logic [DIVW-1:0] divisorShift;
  logic [OW-1:0]   laneOut [LANES];

  // Largest incoming score and the candidate running maximum.
  always_comb begin
    tileMax = $signed(inScores[SW-1:0]);
    for (int k = 1; k < KEYS; k++) begin
      if ($signed(inScores[k*SW +: SW]) > tileMax) tileMax = $signed(inScores[k*SW +: SW]);
    end
    candMax = (tileMax > runMax) ? tileMax : runMax;
  end

  // Rescale path: weight of (new max - old max).
  always_comb begin
    scaleDiffWide = {pendMax[SW-1], pendMax} - {runMax[SW-1], runMax};
    scaleDelta    = scaleDiffWide[SW-1:0];
  end

  osr_expmul #(.DW(SW), .FRAC(SFRAC), .CAP(SUMFRAC), .VALW(AW)) i_scaleSum (
    .delta(scaleDelta), .value(runSum), .product(scaledSum)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_scaleLane
    osr_expmul #(.DW(SW), .FRAC(SFRAC), .CAP(SUMFRAC), .VALW(AW)) i_scaleAcc (
      .delta(scaleDelta), .value(runAcc[l]), .product(scaledAcc[l])
    );
  end

  // Contribution path: weight of (max - score) per key.
  for (genvar k = 0; k < KEYS; k++) begin : g_key
    logic signed [SW:0] diffWide;
    always_comb begin
      diffWide    = {runMax[SW-1], runMax} - {tileScore[k][SW-1], tileScore[k]};
      keyDelta[k] = diffWide[SW-1:0];
    end

    osr_expmul #(.DW(SW), .FRAC(SFRAC), .CAP(SUMFRAC), .VALW(AW)) i_keySum (
      .delta(keyDelta[k]), .value(ONE), .product(keySumTerm[k])
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign keyValExt[k][l] = AW'(tileVal[k][l]) <<< SUMFRAC;
      osr_expmul #(.DW(SW), .FRAC(SFRAC), .CAP(SUMFRAC), .VALW(AW)) i_keyAcc (
        .delta(keyDelta[k]), .value(keyValExt[k][l]), .product(keyAccTerm[k][l])
      );
    end
  end

  always_comb begin
    sumAdd = '0;
    for (int k = 0; k < KEYS; k++) sumAdd = sumAdd + keySumTerm[k];
    for (int l = 0; l < LANES; l++) begin
      accAdd[l] = '0;
      for (int k = 0; k < KEYS; k++) accAdd[l] = accAdd[l] + keyAccTerm[k][l];
    end
  end

  // Divider helpers.
  always_comb begin
    divisorShift = DIVW'($unsigned(runSum)) << bitIdx;
    for (int l = 0; l < LANES; l++) begin
      magAcc[l]  = runAcc[l][AW-1] ? $unsigned(-runAcc[l]) : $unsigned(runAcc[l]);
      laneOut[l] = negRes[l] ? (~{1'b0, quo[l]} + 1'b1) : {1'b0, quo[l]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runMax    <= SCORE_MIN;
      pendMax   <= SCORE_MIN;
      runSum    <= '0;
      doneOut   <= 1'b0;
      outVector <= '0;
      for (int k = 0; k < KEYS; k++) begin
        tileScore[k] <= '0;
        for (int l = 0; l < LANES; l++) tileVal[k][l] <= '0;
      end
      for (int l = 0; l < LANES; l++) begin
        runAcc[l] <= '0;
        rem[l]    <= '0;
        quo[l]    <= '0;
        negRes[l] <= 1'b0;
      end
    end else begin
      doneOut <= ctl.finish;
      if (ctl.capture) begin
        pendMax <= candMax;
        for (int k = 0; k < KEYS; k++) begin
          tileScore[k] <= $signed(inScores[k*SW +: SW]);
          for (int l = 0; l < LANES; l++)
            tileVal[k][l] <= $signed(inValues[(k*LANES+l)*VW +: VW]);
        end
      end
      if (ctl.rescale) begin
        runMax <= pendMax;
        runSum <= scaledSum;
        for (int l = 0; l < LANES; l++) runAcc[l] <= scaledAcc[l];
      end
      if (ctl.accumulate) begin
        runSum <= runSum + sumAdd;
        for (int l = 0; l < LANES; l++) runAcc[l] <= runAcc[l] + accAdd[l];
      end
      if (ctl.divLoad) begin
        for (int l = 0; l < LANES; l++) begin
          rem[l]    <= DIVW'(magAcc[l]) << OFRAC;
          quo[l]    <= '0;
          negRes[l] <= runAcc[l][AW-1];
        end
      end
      if (ctl.divStep) begin
        for (int l = 0; l < LANES; l++) begin
          if (rem[l] >= divisorShift) begin
            rem[l]         <= rem[l] - divisorShift;
            quo[l][bitIdx] <= 1'b1;
          end
        end
      end
      if (ctl.finish) begin
        for (int l = 0; l < LANES; l++) begin
          outVector[l*OW +: OW] <= laneOut[l];
          runAcc[l] <= '0;
        end
        runMax <= SCORE_MIN;
        runSum <= '0;
      end
    end
  end
endmodule

// File: rtl/online_softmax_row.sv
module online_softmax_row
  import osr_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int KEYS    = 2,
  parameter int VW      = 8,
  parameter int SW      = 12,
  parameter int SFRAC   = 4,
  parameter int SUMFRAC = 8,
  parameter int OFRAC   = 4,
  parameter int AW      = 32,
  localparam int OW     = VW + OFRAC + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic                     inLast,
  input  logic [KEYS*SW-1:0]       inScores,
  input  logic [KEYS*LANES*VW-1:0] inValues,
  output logic                     doneOut,
  output logic [LANES*OW-1:0]      outVector
);
  localparam int QW   = OW - 1;
  localparam int IDXW = $clog2(QW);

  osr_strobe_t     ctl;
  logic [IDXW-1:0] bitIdx;

  osr_ctrl #(.QW(QW)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .ctl(ctl), .bitIdx(bitIdx)
  );

  osr_datapath #(
    .LANES(LANES), .KEYS(KEYS), .VW(VW), .SW(SW), .SFRAC(SFRAC),
    .SUMFRAC(SUMFRAC), .OFRAC(OFRAC), .AW(AW)
  ) i_datapath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .bitIdx(bitIdx),
    .inScores(inScores), .inValues(inValues),
    .doneOut(doneOut), .outVector(outVector)
  );
endmodule

// File: rtl/osr_checker.sv
module osr_checker #(
  parameter int OUTW = 56
) (
  input logic            clk,
  input logic            rst_n,
  input logic            inValid,
  input logic            inReady,
  input logic            doneOut,
  input logic [OUTW-1:0] outVector
);
  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> !inReady);

  assert_done_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    doneOut |-> inReady);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    doneOut |=> !doneOut);

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !doneOut |=> ($stable(outVector) || doneOut));

  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doneOut) |-> $past(!inReady));
endmodule

bind online_softmax_row osr_checker #(.OUTW(LANES*OW)) i_osr_checker (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
  .doneOut(doneOut), .outVector(outVector)
);

// File: tb/test_online_softmax_row.sv
module test_online_softmax_row;
  localparam int LANES = 4;
  localparam int KEYS  = 2;
  localparam int VW    = 8;
  localparam int SW    = 12;
  localparam int OW    = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic inLast = 1'b0;
  logic [KEYS*SW-1:0] inScores = '0;
  logic [KEYS*LANES*VW-1:0] inValues = '0;
  logic inReady, doneOut;
  logic [LANES*OW-1:0] outVector;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  int tSc [KEYS];
  int tVa [KEYS][LANES];
  longint mMax, mSum;
  longint mAcc [LANES];
  logic [LANES*OW-1:0] lastVec;
  bit haveLast = 0;

  online_softmax_row i_online_softmax_row (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inLast(inLast), .inScores(inScores), .inValues(inValues),
    .doneOut(doneOut), .outVector(outVector)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wshift(longint d);
    longint s = d >>> 4;
    return (s > 8) ? 8 : int'(s);
  endfunction

  task automatic modelReset();
    mMax = -2048;
    mSum = 0;
    for (int l = 0; l < LANES; l++) mAcc[l] = 0;
  endtask

  task automatic modelTile();
    longint nm = mMax;
    int sh;
    for (int k = 0; k < KEYS; k++) if (tSc[k] > nm) nm = tSc[k];
    sh = wshift(nm - mMax);
    mSum = mSum >>> sh;
    for (int l = 0; l < LANES; l++) mAcc[l] = mAcc[l] >>> sh;
    mMax = nm;
    for (int k = 0; k < KEYS; k++) begin
      sh = wshift(nm - tSc[k]);
      mSum += longint'(256) >>> sh;
      for (int l = 0; l < LANES; l++) mAcc[l] += (longint'(tVa[k][l]) * 256) >>> sh;
    end
  endtask

  function automatic longint expectLane(int l);
    longint mag = (mAcc[l] < 0) ? -mAcc[l] : mAcc[l];
    longint q = (mag * 16) / mSum;
    return (mAcc[l] < 0) ? -q : q;
  endfunction

  function automatic int rnd(int lo, int hi);
    return lo + int'($urandom % unsigned'(hi - lo + 1));
  endfunction

  task automatic driveTile(input bit last);
    while (!inReady) @(negedge clk);
    for (int k = 0; k < KEYS; k++) begin
      inScores[k*SW +: SW] = SW'(tSc[k]);
      for (int l = 0; l < LANES; l++) inValues[(k*LANES+l)*VW +: VW] = VW'(tVa[k][l]);
    end
    inValid = 1'b1;
    inLast  = last;
    @(negedge clk);
    inValid = 1'b0;
    inLast  = 1'b0;
    chk(!inReady, "R2 ready low after accept", inReady, 0);
    modelTile();
  endtask

  task automatic genTile(input int mode, input int t);
    for (int k = 0; k < KEYS; k++) begin
      case (mode)
        0: tSc[k] = 0;
        1: tSc[k] = t * 40 + rnd(0, 10);
        2: tSc[k] = 400 - t * 40 - k * 7;
        4: tSc[k] = (t == 0) ? -2000 : ((k == 0) ? 1500 : -1500);
        default: tSc[k] = rnd(-300, 300);
      endcase
      for (int l = 0; l < LANES; l++)
        tVa[k][l] = (mode == 5) ? (((k + l) % 2 == 0) ? -128 : 127) : rnd(-128, 127);
    end
  endtask

  task automatic runRow(input int n, input int mode, input string tag);
    int cycles = 0;
    bit readyBad = 0;
    bit holdBad = 0;
    logic [LANES*OW-1:0] prevVec;
    modelReset();
    for (int t = 0; t < n; t++) begin
      genTile(mode, t);
      driveTile(t == n - 1);
    end
    while (!doneOut && cycles < 200) begin
      if (inReady) readyBad = 1;
      if (haveLast && outVector !== lastVec) holdBad = 1;
      @(negedge clk);
      cycles++;
    end
    chk(doneOut, "R7 done raised", doneOut, 1);
    chk(!readyBad, "R2 ready low until done", readyBad, 0);
    chk(!holdBad, "R7 output held before done", holdBad, 0);
    for (int l = 0; l < LANES; l++) begin
      longint act = longint'($signed(outVector[l*OW +: OW]));
      longint exp = expectLane(l);
      chk(act == exp, {tag, " R6 R8 lane result"}, act, exp);
    end
    prevVec = outVector;
    @(negedge clk);
    chk(!doneOut, "R7 done single cycle", doneOut, 0);
    chk(outVector == prevVec, "R7 output held after done", 0, 0);
    lastVec = outVector;
    haveLast = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    chk(doneOut == 1'b0, "R1 done low in reset", doneOut, 0);
    chk(inReady == 1'b1, "R1 ready high in reset", inReady, 1);
    chk(outVector == '0, "R1 output zero in reset", 0, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(doneOut == 1'b0 && inReady == 1'b1, "R1 idle after reset", doneOut, 0);

    runRow(1, 0, "R5 equal scores");
    runRow(3, 1, "R4 rising max");
    runRow(3, 2, "R5 falling scores");
    runRow(2, 4, "R3 clipped gap");
    runRow(4, 5, "R6 extreme values");
    runRow(1, 3, "R8 single random");
    for (int r = 0; r < 30; r++) runRow(rnd(1, 6), 3, "R4 R5 random");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule